// File: doc/BRIEF.md
# Byte Datapath with Flag Register and Shift Unit

This block is the execute stage of a small 8-bit controller. Each cycle with `exec_i` high it takes one 18-bit instruction word. It reads an A operand from the destination register of a 16-entry file. The B operand is either the 8-bit constant held in the word or a second register. It runs one operation and, on the rising clock edge, writes the result back and updates the carry and zero flags.

Supported are load, AND/OR/XOR, test, compare, add and subtract with or without carry-in, and one-bit shifts and rotates with a selectable fill bit. Any other opcode has no effect. A read-back port lets a test environment look at any register without disturbing execution. Instruction fetch, branching, port I/O and scratchpad memory sit elsewhere in the controller.

Top module: `byte_alu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, all 16 registers and both flags are cleared.
- R2: The instruction word is laid out as follows. Bits 17:12 are the opcode and bits 11:8 the destination register, which is also operand A. Opcode bit 0 picks operand B: 0 takes the constant in bits 7:0, and 1 takes the register numbered by bits 7:4.
- R3: LOAD (opcodes 000000/000001) copies B into the destination and leaves both flags unchanged.
- R4: AND (001010/001011), OR (001100/001101) and XOR (001110/001111) write the bitwise result, clear carry, and set zero exactly when the 8-bit result is 00.
- R5: TEST (010010/010011) sets zero when A AND B is 00 and clears it otherwise. It clears carry and writes no register.
- R6: COMPARE (010100/010101) writes no register. It sets carry when A < B (unsigned) and zero when A = B, so A > B gives both flags clear.
- R7: ADD (011000/011001) writes A+B, and ADDCY (011010/011011) writes A+B+carry. Carry takes the ninth bit of the sum, and zero reflects the 8-bit result.
- R8: SUB (011100/011101) writes A−B, and SUBCY (011110/011111) writes A−B−carry. Carry is set on borrow, and zero reflects the 8-bit result.
- R9: Shift/rotate (opcode 100000 only) moves A by one bit. Instruction bit 3 sets the direction: 0 is left, 1 is right. Bits 2:1 pick the fill bit: 00 the carry, 01 the A MSB, 10 the A LSB, and 11 the constant in bit 0. The bit shifted out goes to carry, and zero reflects the result.
- R10: With `exec_i` low, no register and no flag changes.
- R11: Opcodes not listed in R3–R9, including 100001, change neither registers nor flags.
- R12: `rd_data_o` shows register `rd_sel_i` combinationally. A write becomes visible just after the edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute the instruction presented this cycle |
| instr_i | input | 18 | Instruction word |
| rd_sel_i | input | 4 | Register number for read-back |
| rd_data_o | output | 8 | Contents of register `rd_sel_i` |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |

## Verification
The hardest case to reach from the ports is a carry-in chain. ADDCY, SUBCY and the carry-fill shifts only show their behaviour when the flag left by the previous instruction is set, and random words rarely line that up. Directed sequences therefore build known operands and chain carry-consuming operations back to back, covering both carry-in values with operands that produce wrap-around. A seeded random stream then mixes every opcode class, including unsupported opcodes and idle cycles, with a bench reference model. After every instruction both flags and the destination register are compared, which also shows that COMPARE and TEST leave the register alone.

// File: rtl/byte_alu_pkg.sv
// Package byte_alu_pkg
// Shared format constants and the operation-group encoding for the byte
// datapath. Assumes the fixed 18-bit instruction layout described in the brief.
package byte_alu_pkg;

    localparam int FMT_DATA_W = 8;   // width of constant and registers
    localparam int FMT_REG_AW = 4;   // register number width
    localparam int FMT_OPC_W  = 6;   // opcode width
    localparam int FMT_FILL_W = 3;   // shift fill-select field width

    // Operation group = opcode bits 5:1; opcode bit 0 selects operand B.
    typedef enum logic [4:0] {
        GRP_LOAD  = 5'b00000,
        GRP_AND   = 5'b00101,
        GRP_OR    = 5'b00110,
        GRP_XOR   = 5'b00111,
        GRP_TEST  = 5'b01001,
        GRP_CMP   = 5'b01010,
        GRP_ADD   = 5'b01100,
        GRP_ADDC  = 5'b01101,
        GRP_SUB   = 5'b01110,
        GRP_SUBC  = 5'b01111,
        GRP_SHIFT = 5'b10000
    } op_grp_e;

endpackage

// File: rtl/byte_alu_decode.sv
// Module byte_alu_decode
// Splits the instruction word into its fields and flags whether the opcode
// is one the datapath executes. Purely combinational.
// Assumes: opcode in the top OPC_W bits, destination next, low DATA_W bits
// hold either a constant or a source register number in their top nibble.
module byte_alu_decode
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = FMT_DATA_W,
    parameter int REG_AW = FMT_REG_AW,
    parameter int OPC_W  = FMT_OPC_W,
    parameter int FILL_W = FMT_FILL_W
) (
    input  logic [OPC_W+REG_AW+DATA_W-1:0] instr,
    output op_grp_e                        grp,
    output logic                           valid,
    output logic                           use_reg,
    output logic [REG_AW-1:0]              dst,
    output logic [REG_AW-1:0]              src,
    output logic [DATA_W-1:0]              konst,
    output logic                           dir_right,
    output logic [FILL_W-1:0]              fill
);

    localparam int INSTR_W = OPC_W + REG_AW + DATA_W;

    logic [OPC_W-1:0] opc;

    // Field extraction.
    always_comb begin
        opc       = instr[INSTR_W-1 -: OPC_W];
        grp       = op_grp_e'(opc[OPC_W-1:1]);
        use_reg   = opc[0];
        dst       = instr[DATA_W +: REG_AW];
        src       = instr[DATA_W-1 -: REG_AW];
        konst     = instr[DATA_W-1:0];
        dir_right = instr[FILL_W];
        fill      = instr[FILL_W-1:0];
    end

    // Opcode legality: listed groups only, shift only with bit 0 clear.
    always_comb begin
        case (opc[OPC_W-1:1])
            GRP_LOAD, GRP_AND, GRP_OR, GRP_XOR, GRP_TEST, GRP_CMP,
            GRP_ADD, GRP_ADDC, GRP_SUB, GRP_SUBC: valid = 1'b1;
            GRP_SHIFT: valid = ~opc[0];
            default:   valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/byte_alu_regfile.sv
// Module byte_alu_regfile
// Register file with one write port and three combinational read ports
// (operand A, operand B, test read-back). Synchronous active-low reset
// clears every entry. Write data is visible on reads after the edge.
module byte_alu_regfile #(
    parameter int DATA_W = 8,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] ra_a,
    input  logic [REG_AW-1:0] ra_b,
    input  logic [REG_AW-1:0] ra_t,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    output logic [DATA_W-1:0] rd_t
);

    localparam int NREGS = 1 << REG_AW;

    logic [DATA_W-1:0] file_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        logic [DATA_W-1:0] q;

        // One storage entry: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == REG_AW'(g))) begin
                q <= wdata;
            end
        end

        assign file_q[g] = q;
    end

    // Read multiplexers.
    always_comb begin
        rd_a = file_q[ra_a];
        rd_b = file_q[ra_b];
        rd_t = file_q[ra_t];
    end

endmodule

// File: rtl/byte_alu_exec.sv
// Module byte_alu_exec
// Combinational execute unit: computes the result, the next carry and zero
// flags, and whether the register and/or flags are to be written.
// Assumes operands already selected; valid=0 suppresses all writes.
module byte_alu_exec
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = FMT_DATA_W,
    parameter int FILL_W = FMT_FILL_W
) (
    input  op_grp_e           grp,
    input  logic              valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              cin,
    input  logic              dir_right,
    input  logic [FILL_W-1:0] fill,
    output logic [DATA_W-1:0] result,
    output logic              cy_next,
    output logic              zf_next,
    output logic              wr_reg,
    output logic              wr_flags
);

    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] zsrc;
    logic              fill_bit;

    // Fill-bit selection for the shift unit.
    always_comb begin
        case (fill[FILL_W-1:1])
            2'b00:   fill_bit = cin;
            2'b01:   fill_bit = op_a[DATA_W-1];
            2'b10:   fill_bit = op_a[0];
            default: fill_bit = fill[0];
        endcase
    end

    // Operation select and flag generation.
    always_comb begin
        result   = '0;
        wide     = '0;
        zsrc     = '0;
        cy_next  = cin;
        wr_reg   = 1'b0;
        wr_flags = 1'b0;
        case (grp)
            GRP_LOAD: begin
                result = op_b;
                wr_reg = 1'b1;
            end
            GRP_AND, GRP_OR, GRP_XOR: begin
                if (grp == GRP_AND)     result = op_a & op_b;
                else if (grp == GRP_OR) result = op_a | op_b;
                else                    result = op_a ^ op_b;
                zsrc     = result;
                cy_next  = 1'b0;
                wr_reg   = 1'b1;
                wr_flags = 1'b1;
            end
            GRP_TEST: begin
                zsrc     = op_a & op_b;
                cy_next  = 1'b0;
                wr_flags = 1'b1;
            end
            GRP_CMP: begin
                wide     = {1'b0, op_a} - {1'b0, op_b};
                zsrc     = wide[DATA_W-1:0];
                cy_next  = wide[DATA_W];
                wr_flags = 1'b1;
            end
            GRP_ADD, GRP_ADDC: begin
                wide = {1'b0, op_a} + {1'b0, op_b}
                     + (DATA_W+1)'((grp == GRP_ADDC) & cin);
                result   = wide[DATA_W-1:0];
                zsrc     = result;
                cy_next  = wide[DATA_W];
                wr_reg   = 1'b1;
                wr_flags = 1'b1;
            end
            GRP_SUB, GRP_SUBC: begin
                wide = {1'b0, op_a} - {1'b0, op_b}
                     - (DATA_W+1)'((grp == GRP_SUBC) & cin);
                result   = wide[DATA_W-1:0];
                zsrc     = result;
                cy_next  = wide[DATA_W];
                wr_reg   = 1'b1;
                wr_flags = 1'b1;
            end
            GRP_SHIFT: begin
                if (dir_right) begin
                    result  = {fill_bit, op_a[DATA_W-1:1]};
                    cy_next = op_a[0];
                end else begin
                    result  = {op_a[DATA_W-2:0], fill_bit};
                    cy_next = op_a[DATA_W-1];
                end
                zsrc     = result;
                wr_reg   = 1'b1;
                wr_flags = 1'b1;
            end
            default: begin
                result = '0;
            end
        endcase
        if (!valid) begin
            wr_reg   = 1'b0;
            wr_flags = 1'b0;
        end
        zf_next = (zsrc == '0);
    end

endmodule

// File: rtl/byte_alu_core.sv
// Module byte_alu_core (top)
// Execute stage of an 8-bit controller: decode, register file, execute unit
// and the carry/zero flag register. One instruction per cycle with exec_i.
// Assumes a synchronous active-low reset and a single clock.
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int DATA_W = FMT_DATA_W,
    parameter int REG_AW = FMT_REG_AW,
    parameter int OPC_W  = FMT_OPC_W,
    parameter int FILL_W = FMT_FILL_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           exec_i,
    input  logic [OPC_W+REG_AW+DATA_W-1:0] instr_i,
    input  logic [REG_AW-1:0]              rd_sel_i,
    output logic [DATA_W-1:0]              rd_data_o,
    output logic                           carry_o,
    output logic                           zero_o
);

    op_grp_e           grp;
    logic              valid;
    logic              use_reg;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src;
    logic [DATA_W-1:0] konst;
    logic              dir_right;
    logic [FILL_W-1:0] fill;
    logic [DATA_W-1:0] rd_a;
    logic [DATA_W-1:0] rd_b;
    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] result;
    logic              cy_next;
    logic              zf_next;
    logic              wr_reg;
    logic              wr_flags;
    logic              carry_q;
    logic              zero_q;

    byte_alu_decode #(
        .DATA_W(DATA_W), .REG_AW(REG_AW), .OPC_W(OPC_W), .FILL_W(FILL_W)
    ) u_dec (
        .instr    (instr_i),
        .grp      (grp),
        .valid    (valid),
        .use_reg  (use_reg),
        .dst      (dst),
        .src      (src),
        .konst    (konst),
        .dir_right(dir_right),
        .fill     (fill)
    );

    byte_alu_regfile #(
        .DATA_W(DATA_W), .REG_AW(REG_AW)
    ) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (exec_i & wr_reg),
        .waddr(dst),
        .wdata(result),
        .ra_a (dst),
        .ra_b (src),
        .ra_t (rd_sel_i),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .rd_t (rd_data_o)
    );

    // Operand B source: register or embedded constant.
    always_comb begin
        op_b = use_reg ? rd_b : konst;
    end

    byte_alu_exec #(
        .DATA_W(DATA_W), .FILL_W(FILL_W)
    ) u_exe (
        .grp      (grp),
        .valid    (valid),
        .op_a     (rd_a),
        .op_b     (op_b),
        .cin      (carry_q),
        .dir_right(dir_right),
        .fill     (fill),
        .result   (result),
        .cy_next  (cy_next),
        .zf_next  (zf_next),
        .wr_reg   (wr_reg),
        .wr_flags (wr_flags)
    );

    // Flag register: cleared on reset, updated by flag-writing operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else if (exec_i && wr_flags) begin
            carry_q <= cy_next;
            zero_q  <= zf_next;
        end
    end

    assign carry_o = carry_q;
    assign zero_o  = zero_q;

endmodule

// File: rtl/byte_alu_core_chk.sv
// Module byte_alu_core_chk
// Port-level checker for byte_alu_core, bound to every instance of it.
// Opcode classes are recomputed here from the instruction port.
module byte_alu_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exec_i,
    input logic [17:0] instr_i,
    input logic [3:0]  rd_sel_i,
    input logic [7:0]  rd_data_o,
    input logic        carry_o,
    input logic        zero_o
);

    logic [4:0] grp;
    logic       is_logic;
    logic       is_noreg;
    logic       is_zwrite;
    logic       dst_seen;

    // Classify the presented instruction.
    always_comb begin
        grp       = instr_i[17:13];
        is_logic  = (grp == 5'b00101) || (grp == 5'b00110) ||
                    (grp == 5'b00111) || (grp == 5'b01001);
        is_noreg  = (grp == 5'b01001) || (grp == 5'b01010);
        is_zwrite = (grp == 5'b00101) || (grp == 5'b00110) ||
                    (grp == 5'b00111) || (grp[4:2] == 3'b011) ||
                    (instr_i[17:12] == 6'b100000);
        dst_seen  = (rd_sel_i == instr_i[11:8]);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!carry_o && !zero_o)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(carry_o) && $stable(zero_o))); // R10

    AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && grp == 5'b00000) |=> ($stable(carry_o) && $stable(zero_o))); // R3

    AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && is_logic) |=> !carry_o); // R4

    AST_CMP_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && is_noreg && dst_seen) |=>
        ((rd_sel_i != $past(rd_sel_i)) || $stable(rd_data_o))); // R6

    AST_ZERO_MATCHES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && is_zwrite && dst_seen) |=>
        ((rd_sel_i != $past(rd_sel_i)) || (zero_o == (rd_data_o == 8'h00)))); // R7

endmodule

bind byte_alu_core byte_alu_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_i   (exec_i),
    .instr_i  (instr_i),
    .rd_sel_i (rd_sel_i),
    .rd_data_o(rd_data_o),
    .carry_o  (carry_o),
    .zero_o   (zero_o)
);

// File: tb/sim_byte_alu_core.sv
`timescale 1ns/1ps
// Bench for byte_alu_core: directed carry chains and corner cases, then a
// seeded random instruction stream checked against a reference model.
module sim_byte_alu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [17:0] instr_i = '0;
    logic [3:0]  rd_sel_i = '0;
    logic [7:0]  rd_data_o;
    logic        carry_o;
    logic        zero_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int mdl [16];
    int mc;
    int mz;

    always #2.5 clk = ~clk;

    byte_alu_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_i   (exec_i),
        .instr_i  (instr_i),
        .rd_sel_i (rd_sel_i),
        .rd_data_o(rd_data_o),
        .carry_o  (carry_o),
        .zero_o   (zero_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic string req_of(input logic [5:0] op);
        case (op[5:1])
            5'b00000: return "R3";
            5'b00101, 5'b00110, 5'b00111: return "R4";
            5'b01001: return "R5";
            5'b01010: return "R6";
            5'b01100, 5'b01101: return "R7";
            5'b01110, 5'b01111: return "R8";
            5'b10000: return (op[0] ? "R11" : "R9");
            default:  return "R11";
        endcase
    endfunction

    task automatic put(input int d, input int r, input int c);
        mdl[d] = r & 255;
        mc = c;
        mz = ((r & 255) == 0) ? 1 : 0;
    endtask

    // Reference model from the requirements.
    task automatic model_apply(input logic [17:0] ins);
        logic [5:0] op;
        int d, a, b, r, fb;
        op = ins[17:12];
        d  = int'(ins[11:8]);
        a  = mdl[d];
        b  = op[0] ? mdl[int'(ins[7:4])] : int'(ins[7:0]);
        case (op[5:1])
            5'b00000: mdl[d] = b;
            5'b00101: put(d, a & b, 0);
            5'b00110: put(d, a | b, 0);
            5'b00111: put(d, a ^ b, 0);
            5'b01001: begin mc = 0; mz = ((a & b) == 0) ? 1 : 0; end
            5'b01010: begin mc = (a < b) ? 1 : 0; mz = (a == b) ? 1 : 0; end
            5'b01100: begin r = a + b; put(d, r, r > 255 ? 1 : 0); end
            5'b01101: begin r = a + b + mc; put(d, r, r > 255 ? 1 : 0); end
            5'b01110: begin r = a - b; put(d, r + 256, r < 0 ? 1 : 0); end
            5'b01111: begin r = a - b - mc; put(d, r + 256, r < 0 ? 1 : 0); end
            5'b10000: if (!op[0]) begin
                case (ins[2:1])
                    2'b00: fb = mc;
                    2'b01: fb = (a >> 7) & 1;
                    2'b10: fb = a & 1;
                    default: fb = int'(ins[0]);
                endcase
                if (ins[3]) put(d, (a >> 1) | (fb << 7), a & 1);
                else        put(d, ((a << 1) & 255) | fb, (a >> 7) & 1);
            end
            default: ;
        endcase
    endtask

    // Execute one instruction and compare flags and destination.
    task automatic step(input logic [17:0] ins);
        string tag;
        tag = req_of(ins[17:12]);
        @(negedge clk);
        instr_i = ins;
        exec_i  = 1'b1;
        @(posedge clk);
        model_apply(ins);
        @(negedge clk);
        exec_i   = 1'b0;
        rd_sel_i = ins[11:8];
        #1;
        chk({tag, " flags"}, {carry_o, zero_o}, (mc << 1) | mz);
        chk({tag, " dest R12"}, rd_data_o, mdl[int'(ins[11:8])]);
    endtask

    task automatic expect_now(input string tag, input int reg_no,
                              input int val, input int c);
        rd_sel_i = 4'(reg_no);
        #1;
        chk({tag, " value"}, rd_data_o, val);
        chk({tag, " carry"}, carry_o, c);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_sel_i = 4'(i);
            #1;
            chk(tag, rd_data_o, mdl[i]);
        end
        chk({tag, " flags"}, {carry_o, zero_o}, (mc << 1) | mz);
    endtask

    function automatic logic [17:0] ik(input logic [5:0] op, input int d, input int k);
        return {op, 4'(d), 8'(k)};
    endfunction

    function automatic logic [17:0] ir(input logic [5:0] op, input int d, input int s);
        return {op, 4'(d), 4'(s), 4'h0};
    endfunction

    function automatic logic [17:0] ish(input int d, input bit right, input logic [2:0] f);
        return {6'b100000, 4'(d), 4'h0, right, f};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exec_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mdl[i] = 0;
        mc = 0;
        mz = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [5:0] ops [22];
        void'($urandom(32'h5eed_0a1c));
        ops = '{6'b000000, 6'b000001, 6'b001010, 6'b001011, 6'b001100,
                6'b001101, 6'b001110, 6'b001111, 6'b010010, 6'b010011,
                6'b010100, 6'b010101, 6'b011000, 6'b011001, 6'b011010,
                6'b011011, 6'b011100, 6'b011101, 6'b011110, 6'b011111,
                6'b100000, 6'b100001};

        // R1: reset state
        repeat (2) @(posedge clk);
        do_reset();
        check_all("R1 reset");

        // R7: add chain with constants, then with registers (R2)
        step(ik(6'b000000, 0, 8'h0F));
        step(ik(6'b011000, 0, 8'h31)); expect_now("R7 add", 0, 8'h40, 0);
        step(ik(6'b011010, 0, 8'hF0)); expect_now("R7 addcy", 0, 8'h30, 1);
        step(ik(6'b011010, 0, 8'hF0)); expect_now("R7 addcy cin", 0, 8'h21, 1);
        step(ik(6'b000000, 0, 8'h0F));
        step(ik(6'b000000, 1, 8'h31));
        step(ik(6'b000000, 2, 8'hF0));
        step(ir(6'b011001, 0, 1)); expect_now("R2 add reg", 0, 8'h40, 0);
        step(ir(6'b011011, 0, 2));
        step(ir(6'b011011, 0, 2)); expect_now("R2 addcy reg", 0, 8'h21, 1);

        // R8: subtract chain
        step(ik(6'b000000, 1, 8'h0F));
        step(ik(6'b011100, 1, 8'h0C)); expect_now("R8 sub", 1, 8'h03, 0);
        step(ik(6'b011110, 1, 8'hF0)); expect_now("R8 subcy", 1, 8'h13, 1);
        step(ik(6'b011110, 1, 8'hF0)); expect_now("R8 subcy bin", 1, 8'h22, 1);

        // R9: right-shift sequence from 0F
        step(ik(6'b000000, 3, 8'h0F));
        step(ish(3, 1, 3'b110)); expect_now("R9 sr0", 3, 8'h07, 1);
        step(ish(3, 1, 3'b010)); expect_now("R9 srx", 3, 8'h03, 1);
        step(ish(3, 1, 3'b111)); expect_now("R9 sr1", 3, 8'h81, 1);
        step(ish(3, 1, 3'b010)); expect_now("R9 srx msb", 3, 8'hC0, 1);
        step(ish(3, 1, 3'b000)); expect_now("R9 sra", 3, 8'hE0, 0);
        step(ish(3, 1, 3'b000)); expect_now("R9 sra c0", 3, 8'h70, 0);
        // R9: left-shift sequence from F0
        step(ik(6'b000000, 4, 8'hF0));
        step(ish(4, 0, 3'b110)); expect_now("R9 sl0", 4, 8'hE0, 1);
        step(ish(4, 0, 3'b100)); expect_now("R9 slx", 4, 8'hC0, 1);
        step(ish(4, 0, 3'b111)); expect_now("R9 sl1", 4, 8'h81, 1);
        step(ish(4, 0, 3'b100)); expect_now("R9 slx lsb", 4, 8'h03, 1);
        step(ish(4, 0, 3'b000)); expect_now("R9 sla", 4, 8'h07, 0);
        step(ish(4, 0, 3'b000)); expect_now("R9 sla c0", 4, 8'h0E, 0);

        // R6: compare less, equal, greater
        step(ik(6'b000000, 5, 8'h0F));
        step(ik(6'b010100, 5, 8'hF0)); chk("R6 lt", {carry_o, zero_o}, 2);
        step(ir(6'b010101, 5, 5));     chk("R6 eq", zero_o, 1);
        step(ik(6'b010100, 5, 8'h08)); chk("R6 gt", {carry_o, zero_o}, 0);
        // R5: test
        step(ik(6'b010010, 5, 8'hF0)); chk("R5 and zero", zero_o, 1);
        step(ik(6'b010010, 5, 8'hFF)); chk("R5 and nonzero", zero_o, 0);
        // R4: logic clears carry
        step(ik(6'b011000, 6, 8'hFF));
        step(ik(6'b011000, 6, 8'h01));
        step(ik(6'b001100, 6, 8'h00)); chk("R4 or clears carry", carry_o, 0);

        // R10: instruction held with exec_i low
        @(negedge clk);
        instr_i = ik(6'b000000, 5, 8'hAA);
        repeat (3) @(negedge clk);
        check_all("R10 idle");
        // R11: unsupported opcodes
        step(ik(6'b000100, 7, 8'h55));
        step(ik(6'b100001, 5, 8'h0F));
        step(ik(6'b111111, 5, 8'hFF));
        check_all("R11 ignored");

        // Mid-run reset (R1)
        do_reset();
        check_all("R1 mid reset");

        // Seeded random stream mixed with idle cycles and illegal codes
        for (int n = 0; n < 3000; n++) begin
            logic [17:0] w;
            w = 18'($urandom);
            if (($urandom % 8) != 0) w[17:12] = ops[$urandom % 22];
            if (($urandom % 16) == 0) begin
                @(negedge clk);
                instr_i = w;
                @(negedge clk);
            end else begin
                step(w);
            end
        end
        check_all("R10 R11 random end");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule